// File: doc/BRIEF.md
# Self-Repairing Triplicated Weight Store

This block keeps the programmable weights of an on-detector compression encoder in a form that survives single-event upsets. Every weight word is held in three separate register copies. A bitwise majority of the three copies is the value the arithmetic sees and the value the host reads back. On every clock the voted value is written into all copies, so a single disturbed copy heals one cycle after the upset.

A host port with a single address, write strobe and write data loads weights and reads them back. The host also reaches a small status word that carries two sticky disagreement flags. The same block contains a pass-through data stage built in the lighter style. It has three registered copies of the incoming sample and a voter on the output, and no write-back, because a fresh sample replaces the stage every cycle.

A fault-injection port flips chosen bits in one chosen copy, either of a weight or of the data stage. This lets both protection styles be exercised through the block's edge. No error-correcting code is stored anywhere.

Top module: `tmr_weight_bank`

## Requirements
- R1: While reset is asserted and right after it, every weight reads 0, `dout` is 0 and both status flags are 0.
- R2: A host write with `h_addr[5]`=0 loads `h_wdata` into all three copies of weight `h_addr[4:0]`. The new value appears on `weights_o[i*6 +: 6]` and on `h_rdata` from the next cycle.
- R3: A read with `h_addr[5]`=0 returns, without a clock delay, the majority of the three copies of that weight. It never returns a single copy.
- R4: Each cycle the voted value is written back into every copy of every weight. A flip in one copy in one cycle followed by the same flip in a second copy in the next cycle leaves the voted weight unchanged.
- R5: A host write and an injection that target the same weight in the same cycle resolve to the written value. The write wins, so no disagreement is recorded.
- R6: Status bit 0 becomes 1 in the cycle after any weight copy differs from its vote. It stays 1 until cleared.
- R7: Writing to any address with `h_addr[5]`=1 clears status bit 0 where `h_wdata[0]`=1 and status bit 1 where `h_wdata[1]`=1. A disagreement pending in the same cycle keeps its bit set.
- R8: `dout` equals the `din` of the previous cycle. It is the majority of three registered copies, so a flip in any single copy is masked.
- R9: The data stage has no feedback. Upsets in different copies in consecutive cycles are each masked, and status bit 1 is set in the cycle after a data copy disagrees.
- R10: A read with `h_addr[5]`=1 returns {0000, bit1 = data-stage flag, bit0 = weight flag}. An injection with `inj_copy`=3 touches no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 6 | Bit 5 selects status, bits 4:0 select a weight |
| h_wdata | input | 6 | Host write data |
| h_rdata | output | 6 | Voted weight or status word |
| weights_o | output | 192 | All voted weights, word i at bits i*6 +: 6 |
| din | input | 8 | Data sample entering the stage |
| dout | output | 8 | Voted registered sample |
| inj_en | input | 1 | Apply a fault this cycle |
| inj_pipe | input | 1 | 1 targets the data stage, 0 targets a weight |
| inj_copy | input | 2 | Copy 0, 1 or 2 to disturb, 3 selects none |
| inj_addr | input | 5 | Weight index for a weight fault |
| inj_mask | input | 8 | Bits to flip, low 6 bits used for weights |

## Verification
On every cycle the assertions check four things. A host write shows up in the voted weight one cycle later. Any cycle without a weight fault leaves all copies in agreement one cycle later, which is the scrub. The weight flag rises after a disagreement and holds until it is cleared. The data output always equals the previous input. Only the bench scenarios can show the rest. One of them stacks upsets on a second copy after the first has been repaired. Others exercise a write and a fault colliding on the same weight, a clear racing against a new disagreement, and a null copy selection that must change nothing.

// File: rtl/tmr_weight_bank.sv
module tmr_weight_bank #(
  parameter int NW = 32,
  parameter int AW = 5,
  parameter int WW = 6,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we,
  input  logic [AW:0]      h_addr,
  input  logic [WW-1:0]    h_wdata,
  output logic [WW-1:0]    h_rdata,
  output logic [NW*WW-1:0] weights_o,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  input  logic             inj_en,
  input  logic             inj_pipe,
  input  logic [1:0]       inj_copy,
  input  logic [AW-1:0]    inj_addr,
  input  logic [DW-1:0]    inj_mask
);

  logic [WW-1:0] ca [NW];
  logic [WW-1:0] cb [NW];
  logic [WW-1:0] cc [NW];
  logic [WW-1:0] vt [NW];
  logic [NW-1:0] dis;
  logic [DW-1:0] pa, pb, pc;
  logic [1:0]    flag_q;
  logic          live;

  wire w_wr   = h_we && !h_addr[AW];
  wire st_wr  = h_we && h_addr[AW];
  wire b_inj  = inj_en && !inj_pipe;
  wire p_inj  = inj_en && inj_pipe;
  wire [WW-1:0] bmask = inj_mask[WW-1:0];

  for (genvar i = 0; i < NW; i++) begin : g_vote
    assign vt[i] = (ca[i] & cb[i]) | (ca[i] & cc[i]) | (cb[i] & cc[i]);
    assign dis[i] = (ca[i] != vt[i]) || (cb[i] != vt[i]) || (cc[i] != vt[i]);
    assign weights_o[i*WW +: WW] = vt[i];
  end

  wire bank_mis = |dis;
  wire pipe_mis = (pa != dout) || (pb != dout) || (pc != dout);

  assign dout = (pa & pb) | (pa & pc) | (pb & pc);
  assign h_rdata = h_addr[AW] ? {{(WW-2){1'b0}}, flag_q} : vt[h_addr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        ca[i] <= '0;
        cb[i] <= '0;
        cc[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (w_wr && h_addr[AW-1:0] == AW'(i)) begin
          ca[i] <= h_wdata;
          cb[i] <= h_wdata;
          cc[i] <= h_wdata;
        end else begin
          ca[i] <= vt[i] ^ ((b_inj && inj_addr == AW'(i) && inj_copy == 2'd0) ? bmask : '0);
          cb[i] <= vt[i] ^ ((b_inj && inj_addr == AW'(i) && inj_copy == 2'd1) ? bmask : '0);
          cc[i] <= vt[i] ^ ((b_inj && inj_addr == AW'(i) && inj_copy == 2'd2) ? bmask : '0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= '0;
      pb <= '0;
      pc <= '0;
      flag_q <= '0;
      live <= 1'b0;
    end else begin
      pa <= din ^ ((p_inj && inj_copy == 2'd0) ? inj_mask : '0);
      pb <= din ^ ((p_inj && inj_copy == 2'd1) ? inj_mask : '0);
      pc <= din ^ ((p_inj && inj_copy == 2'd2) ? inj_mask : '0);
      flag_q[0] <= (flag_q[0] & ~(st_wr & h_wdata[0])) | bank_mis;
      flag_q[1] <= (flag_q[1] & ~(st_wr & h_wdata[1])) | pipe_mis;
      live <= 1'b1;
    end
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    w_wr |=> vt[$past(h_addr[AW-1:0])] == $past(h_wdata));

  a_r4_scrub_heals: assert property (@(posedge clk) disable iff (!rst_n)
    !b_inj |=> !bank_mis);

  a_r6_flag_rises: assert property (@(posedge clk) disable iff (!rst_n)
    bank_mis |=> flag_q[0]);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(st_wr && h_wdata[0])) |=> flag_q[0]);

  a_r8_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> dout == $past(din));

endmodule

// File: tb/sim_tmr_weight_bank.sv
module sim_tmr_weight_bank;
  logic clk = 0, rst_n = 0;
  logic h_we = 0;
  logic [5:0] h_addr = 0;
  logic [5:0] h_wdata = 0;
  logic [5:0] h_rdata;
  logic [191:0] weights_o;
  logic [7:0] din = 0, dout;
  logic inj_en = 0, inj_pipe = 0;
  logic [1:0] inj_copy = 0;
  logic [4:0] inj_addr = 0;
  logic [7:0] inj_mask = 0;

  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 0;

  int mw [32];
  int md = 0, fb = 0, fp = 0, pb = 0, pp = 0;

  always #10 clk = ~clk;

  tmr_weight_bank u0 (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mw[i]) mw[i] = 0;
      md = 0; fb = 0; fp = 0; pb = 0; pp = 0;
    end else begin
      if (h_we && h_addr[5]) begin
        if (h_wdata[0]) fb = 0;
        if (h_wdata[1]) fp = 0;
      end
      fb = fb | pb;
      fp = fp | pp;
      pb = (inj_en && !inj_pipe && inj_copy != 3 && inj_mask[5:0] != 0 &&
            !(h_we && !h_addr[5] && h_addr[4:0] == inj_addr)) ? 1 : 0;
      pp = (inj_en && inj_pipe && inj_copy != 3 && inj_mask != 0) ? 1 : 0;
      if (h_we && !h_addr[5]) mw[h_addr[4:0]] = h_wdata;
      md = din;
    end
  end

  function automatic int exp_rd();
    if (h_addr[5]) return fp * 2 + fb;
    return mw[h_addr[4:0]];
  endfunction

  always @(negedge clk) if (!done) begin
    int ok;
    ok = 1;
    for (int i = 0; i < 32; i++) if (weights_o[i*6 +: 6] != mw[i][5:0]) ok = 0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s weights_o act=%h exp word0=%0d", tag, weights_o, mw[0]);
    end
    total++;
    if (dout != md[7:0]) begin
      bad++;
      $display("FAIL %s dout act=%0d exp=%0d", tag, dout, md);
    end
    total++;
    if (h_rdata != exp_rd()) begin
      bad++;
      $display("FAIL %s h_rdata addr=%0d act=%0d exp=%0d", tag, h_addr, h_rdata, exp_rd());
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle();
    h_we = 0; inj_en = 0;
  endtask

  task automatic wr(int a, int d);
    h_we = 1; h_addr = 6'(a); h_wdata = 6'(d);
  endtask

  task automatic inj(bit p, int c, int a, int m);
    inj_en = 1; inj_pipe = p; inj_copy = 2'(c); inj_addr = 5'(a); inj_mask = 8'(m);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1"; din = 8'h5A;
    cyc(3);
    rst_n = 1;
    cyc(2);

    // R2: writes land in all copies, R3: combinational readback
    tag = "R2";
    wr(0, 6'h2A); cyc(); wr(31, 6'h3F); cyc(); wr(7, 6'h11); cyc();
    idle(); h_addr = 31; cyc(); h_addr = 0; cyc();
    tag = "R3"; h_addr = 7; cyc();

    // R4: stacked upsets on different copies, healed each cycle; R6 flag
    tag = "R4";
    inj(0, 0, 7, 6'h3F); cyc();
    inj(0, 1, 7, 6'h3F); cyc();
    inj(0, 2, 7, 6'h01); cyc();
    tag = "R6"; idle(); cyc(3);
    h_addr = 6'h20; cyc();

    // R7: clear, then a clear racing a pending disagreement
    tag = "R7";
    wr(6'h20, 1); cyc(); idle(); cyc();
    inj(0, 1, 31, 6'h04); cyc();
    idle(); wr(6'h20, 1); cyc();
    idle(); h_addr = 6'h20; cyc();
    tag = "R6"; wr(6'h20, 0); cyc(); idle(); cyc();
    tag = "R7"; wr(6'h20, 1); cyc(); idle(); h_addr = 6'h20; cyc();

    // R5: write versus injection on the same weight
    tag = "R5";
    wr(3, 6'h15); inj(0, 2, 3, 6'h3F); cyc();
    idle(); h_addr = 6'h20; cyc(); h_addr = 3; cyc();

    // R10: null copy selection changes nothing
    tag = "R10";
    inj(0, 3, 7, 6'h3F); cyc(); inj(1, 3, 0, 8'hFF); cyc();
    idle(); h_addr = 6'h20; cyc(); h_addr = 7; cyc();

    // R8/R9: data stage under changing samples and per-copy upsets
    tag = "R8";
    for (int k = 0; k < 12; k++) begin
      din = 8'((k * 37 + 11) & 255);
      cyc();
    end
    tag = "R9";
    for (int k = 0; k < 9; k++) begin
      din = 8'((k * 91 + 5) & 255);
      inj(1, k % 3, 0, 8'(1 << (k % 8)));
      cyc();
    end
    idle(); din = 8'hC3; h_addr = 6'h20; cyc(2);
    tag = "R7"; wr(6'h20, 2); cyc(); idle(); cyc(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule